// File: doc/BRIEF.md
# Segment Register Load Unit

This block holds the segment registers of a small processor core and carries out a write to one of them. Each segment has a selector that software can see and a hidden cache with a base, a limit and an attribute byte. When a load request arrives, the unit picks one of three update paths. The choice depends on three things: the source of the new selector (a general register or memory), the mode the instruction was decoded in, and the live protection-enable bit at execution time. It then writes the chosen segment and reports the resulting contents one cycle later, together with a done strobe.

Descriptor fetching, privilege checks and fault reporting are handled elsewhere. A protected-mode load takes its base, limit and attributes from the descriptor input port, which must be valid in the same cycle as the request. The decode-time mode tag matters only for register-source loads. Memory-source loads share one path that looks only at the live enable bit. Because of this, an instruction that was decoded just before protection was switched on can behave differently depending on where its operand comes from.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, every segment has selector 0, base 0, limit 0xFFFF and attributes 0. The done output is low, and the result outputs show those values for segment index 0.
- R2: A request sampled at a clock edge raises done for the following cycle only. The result outputs then show the index of the addressed segment and its new contents. With no request, done is low.
- R3: A real-mode load sets the selector to the new value and sets the base to the selector shifted left by four bits, zero-extended to the base width.
- R4: A real-mode load leaves the cached limit and attributes exactly as they were. The limit is not reset to 0xFFFF.
- R5: A large limit cached by a protected-mode load stays in force through later real-mode loads of the same segment.
- R6: A memory-source load executed with the enable bit set writes the selector and takes base, limit and attributes from the descriptor input, whatever the decode mode tag says.
- R7: A memory-source load executed with the enable bit clear uses real-mode semantics, whatever the decode mode tag says.
- R8: A register-source load tagged as decoded in real mode and executed with the enable bit clear uses real-mode semantics.
- R9: A register-source load tagged as decoded in real mode but executed with the enable bit set changes only the selector. Base, limit and attributes keep their previous values.
- R10: A register-source load tagged as decoded in protected mode uses protected-mode semantics, with all three cache fields taken from the descriptor input.
- R11: A load changes only the addressed segment. The other segments keep their selector and cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request, one cycle per load |
| ld_seg | input | IDX_W | Index of the segment to write |
| ld_from_mem | input | 1 | 1: selector comes from memory, 0: from a general register |
| ld_dec_real | input | 1 | 1: instruction was decoded in real mode |
| pe_live | input | 1 | Protection-enable bit at execution time |
| ld_sel | input | SEL_W | New selector value |
| desc_base | input | BASE_W | Base field of the fetched descriptor |
| desc_limit | input | LIM_W | Limit field of the fetched descriptor |
| desc_attr | input | ATTR_W | Attribute field of the fetched descriptor |
| done | output | 1 | Load completed in the previous cycle |
| out_seg | output | IDX_W | Index of the segment just written |
| out_sel | output | SEL_W | Selector of that segment after the load |
| out_base | output | BASE_W | Cached base after the load |
| out_limit | output | LIM_W | Cached limit after the load |
| out_attr | output | ATTR_W | Cached attributes after the load |

## Verification
The assertions assume that a request uses a segment index below the segment count, and that the descriptor fields are stable and meaningful in the cycle of any load that ends on the protected path. The bench drives only indices 0 to 3 with the default count of four, and it always supplies a full descriptor with each request. It also gives the descriptor non-zero values when it expects them to be ignored, so that a wrongly taken protected path shows up in the outputs. It drives every request for exactly one cycle and then holds the request low for a cycle, which matches the one-cycle done relation the properties check.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    ACT_REAL     = 2'd0,
    ACT_PROT     = 2'd1,
    ACT_SEL_ONLY = 2'd2
  } srl_act_e;
endpackage

// File: rtl/srl_path_sel.sv
module srl_path_sel
  import srl_pkg::*;
(
  input  logic     from_mem,
  input  logic     dec_real,
  input  logic     pe_live,
  output srl_act_e act
);
  always_comb begin
    if (from_mem) begin
      // shared path: mode decided at execution time
      act = pe_live ? ACT_PROT : ACT_REAL;
    end else if (dec_real) begin
      // real-mode register entry: PE set late only reaches the selector
      act = pe_live ? ACT_SEL_ONLY : ACT_REAL;
    end else begin
      act = ACT_PROT;
    end
  end
endmodule

// File: rtl/srl_update.sv
module srl_update
  import srl_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 32,
  parameter int ATTR_W = 8
) (
  input  srl_act_e           act,
  input  logic [SEL_W-1:0]   ld_sel,
  input  logic [BASE_W-1:0]  desc_base,
  input  logic [LIM_W-1:0]   desc_limit,
  input  logic [ATTR_W-1:0]  desc_attr,
  input  logic [BASE_W-1:0]  old_base,
  input  logic [LIM_W-1:0]   old_limit,
  input  logic [ATTR_W-1:0]  old_attr,
  output logic [SEL_W-1:0]   nw_sel,
  output logic [BASE_W-1:0]  nw_base,
  output logic [LIM_W-1:0]   nw_limit,
  output logic [ATTR_W-1:0]  nw_attr
);
  localparam int SHIFT_W = SEL_W + 4;

  logic [SHIFT_W-1:0] para_base;
  assign para_base = {ld_sel, 4'h0};

  always_comb begin
    nw_sel   = ld_sel;
    nw_base  = old_base;
    nw_limit = old_limit;
    nw_attr  = old_attr;
    unique case (act)
      ACT_REAL: nw_base = BASE_W'(para_base);
      ACT_PROT: begin
        nw_base  = desc_base;
        nw_limit = desc_limit;
        nw_attr  = desc_attr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/srl_seg_entry.sv
module srl_seg_entry #(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 32,
  parameter int ATTR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic [LIM_W-1:0]   wr_limit,
  input  logic [ATTR_W-1:0]  wr_attr,
  output logic [SEL_W-1:0]   q_sel,
  output logic [BASE_W-1:0]  q_base,
  output logic [LIM_W-1:0]   q_limit,
  output logic [ATTR_W-1:0]  q_attr
);
  localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(32'h0000_FFFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_sel   <= '0;
      q_base  <= '0;
      q_limit <= LIM_RST;
      q_attr  <= '0;
    end else if (wr_en) begin
      q_sel   <= wr_sel;
      q_base  <= wr_base;
      q_limit <= wr_limit;
      q_attr  <= wr_attr;
    end
  end

  // R11: an entry that is not written keeps its contents
  a_r11_idle_entry_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(q_sel) && $stable(q_base) && $stable(q_limit) && $stable(q_attr)));
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import srl_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 32,
  parameter int ATTR_W = 8,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [IDX_W-1:0]   ld_seg,
  input  logic               ld_from_mem,
  input  logic               ld_dec_real,
  input  logic               pe_live,
  input  logic [SEL_W-1:0]   ld_sel,
  input  logic [BASE_W-1:0]  desc_base,
  input  logic [LIM_W-1:0]   desc_limit,
  input  logic [ATTR_W-1:0]  desc_attr,
  output logic               done,
  output logic [IDX_W-1:0]   out_seg,
  output logic [SEL_W-1:0]   out_sel,
  output logic [BASE_W-1:0]  out_base,
  output logic [LIM_W-1:0]   out_limit,
  output logic [ATTR_W-1:0]  out_attr
);
  localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(32'h0000_FFFF);

  srl_act_e act;

  logic [SEL_W-1:0]  q_sel   [NSEG];
  logic [BASE_W-1:0] q_base  [NSEG];
  logic [LIM_W-1:0]  q_limit [NSEG];
  logic [ATTR_W-1:0] q_attr  [NSEG];

  logic [BASE_W-1:0] old_base;
  logic [LIM_W-1:0]  old_limit;
  logic [ATTR_W-1:0] old_attr;

  logic [SEL_W-1:0]  nw_sel;
  logic [BASE_W-1:0] nw_base;
  logic [LIM_W-1:0]  nw_limit;
  logic [ATTR_W-1:0] nw_attr;

  srl_path_sel u_path (
    .from_mem (ld_from_mem),
    .dec_real (ld_dec_real),
    .pe_live  (pe_live),
    .act      (act)
  );

  assign old_base  = q_base[ld_seg];
  assign old_limit = q_limit[ld_seg];
  assign old_attr  = q_attr[ld_seg];

  srl_update #(
    .SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .ATTR_W(ATTR_W)
  ) u_upd (
    .act        (act),
    .ld_sel     (ld_sel),
    .desc_base  (desc_base),
    .desc_limit (desc_limit),
    .desc_attr  (desc_attr),
    .old_base   (old_base),
    .old_limit  (old_limit),
    .old_attr   (old_attr),
    .nw_sel     (nw_sel),
    .nw_base    (nw_base),
    .nw_limit   (nw_limit),
    .nw_attr    (nw_attr)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    srl_seg_entry #(
      .SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .ATTR_W(ATTR_W)
    ) u_ent (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (ld_valid && (ld_seg == IDX_W'(g))),
      .wr_sel   (nw_sel),
      .wr_base  (nw_base),
      .wr_limit (nw_limit),
      .wr_attr  (nw_attr),
      .q_sel    (q_sel[g]),
      .q_base   (q_base[g]),
      .q_limit  (q_limit[g]),
      .q_attr   (q_attr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      out_seg   <= '0;
      out_sel   <= '0;
      out_base  <= '0;
      out_limit <= LIM_RST;
      out_attr  <= '0;
    end else begin
      done <= ld_valid;
      if (ld_valid) begin
        out_seg   <= ld_seg;
        out_sel   <= nw_sel;
        out_base  <= nw_base;
        out_limit <= nw_limit;
        out_attr  <= nw_attr;
      end
    end
  end

  // R2: done follows each request by one cycle
  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (done && out_seg == $past(ld_seg)));
  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> !done);
  // R3: real path forms the base from the selector
  a_r3_real_base: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && act == ACT_REAL) |=>
      (out_base[3:0] == 4'h0 && out_base[SEL_W+3:4] == $past(ld_sel)));
  // R4: real path keeps limit and attributes
  a_r4_real_keeps_limit: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && act == ACT_REAL) |=>
      (out_limit == $past(old_limit) && out_attr == $past(old_attr)));
  // R7: memory source with PE clear takes the real path
  a_r7_mem_pe_clear_real: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_from_mem && !pe_live) |-> act == ACT_REAL);
  // R6, R10: protected path copies the descriptor
  a_r6_prot_copies_desc: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && act == ACT_PROT) |=>
      (out_base == $past(desc_base) && out_limit == $past(desc_limit) &&
       out_attr == $past(desc_attr)));
  // R9: late PE on a real-decoded register load touches only the selector
  a_r9_sel_only: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ld_from_mem && ld_dec_real && pe_live) |=>
      (out_sel == $past(ld_sel) && out_base == $past(old_base) &&
       out_limit == $past(old_limit) && out_attr == $past(old_attr)));
endmodule

// File: tb/seg_load_unit_tb.sv
`timescale 1ns/1ps
module seg_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid;
  logic [1:0]  ld_seg;
  logic        ld_from_mem, ld_dec_real, pe_live;
  logic [15:0] ld_sel;
  logic [31:0] desc_base, desc_limit;
  logic [7:0]  desc_attr;
  logic        done;
  logic [1:0]  out_seg;
  logic [15:0] out_sel;
  logic [31:0] out_base, out_limit;
  logic [7:0]  out_attr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  seg_load_unit u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_seg(ld_seg),
    .ld_from_mem(ld_from_mem), .ld_dec_real(ld_dec_real), .pe_live(pe_live),
    .ld_sel(ld_sel), .desc_base(desc_base), .desc_limit(desc_limit),
    .desc_attr(desc_attr), .done(done), .out_seg(out_seg), .out_sel(out_sel),
    .out_base(out_base), .out_limit(out_limit), .out_attr(out_attr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one load, checked one cycle after the request edge, then one idle cycle
  task automatic do_load(input string req, input int seg, input bit mem,
                         input bit treal, input bit pe, input logic [15:0] sel,
                         input logic [31:0] e_base, input logic [31:0] e_lim,
                         input logic [7:0] e_attr);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'(seg); ld_from_mem = mem;
    ld_dec_real = treal; pe_live = pe; ld_sel = sel;
    desc_base = 32'h00A0_0000 + 32'(seg); desc_limit = 32'h000F_FFFF;
    desc_attr = 8'h9B;
    @(negedge clk);
    ld_valid = 1'b0;
    check(req, "done", 32'(done), 32'd1);
    check(req, "seg", 32'(out_seg), 32'(seg));
    check(req, "sel", 32'(out_sel), 32'(sel));
    check(req, "base", out_base, e_base);
    check(req, "limit", out_limit, e_lim);
    check(req, "attr", 32'(out_attr), 32'(e_attr));
    @(negedge clk);
    check("R2", "done idle", 32'(done), 32'd0);
  endtask

  // protected register load with caller-chosen descriptor
  task automatic prot_load(input int seg, input logic [15:0] sel,
                           input logic [31:0] b, input logic [31:0] l,
                           input logic [7:0] a);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'(seg); ld_from_mem = 1'b0;
    ld_dec_real = 1'b0; pe_live = 1'b1; ld_sel = sel;
    desc_base = b; desc_limit = l; desc_attr = a;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R10", "done", 32'(done), 32'd1);
    check("R10", "base", out_base, b);
    check("R10", "limit", out_limit, l);
    check("R10", "attr", 32'(out_attr), 32'(a));
  endtask

  task automatic t_reset;
    rst = 1'b1; ld_valid = 1'b0; ld_seg = '0; ld_from_mem = 1'b0;
    ld_dec_real = 1'b1; pe_live = 1'b0; ld_sel = '0;
    desc_base = '0; desc_limit = '0; desc_attr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done", 32'(done), 32'd0);
    check("R1", "sel", 32'(out_sel), 32'd0);
    check("R1", "base", out_base, 32'd0);
    check("R1", "limit", out_limit, 32'h0000_FFFF);
    check("R1", "attr", 32'(out_attr), 32'd0);
    // untouched segment 3 reveals reset cache through a selector-only load
    do_load("R1", 3, 1'b0, 1'b1, 1'b1, 16'h0000, 32'd0, 32'h0000_FFFF, 8'h00);
  endtask

  task automatic t_real_reg;  // R3 R4 R8
    do_load("R8", 0, 1'b0, 1'b1, 1'b0, 16'h1234, 32'h0001_2340, 32'h0000_FFFF, 8'h00);
    do_load("R3", 0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 32'h000F_FFF0, 32'h0000_FFFF, 8'h00);
  endtask

  task automatic t_big_limit;  // R5 R4 R10
    prot_load(1, 16'h0008, 32'h0010_0000, 32'hFFFF_FFFF, 8'h93);
    @(negedge clk);
    do_load("R5", 1, 1'b0, 1'b1, 1'b0, 16'h0040, 32'h0000_0400, 32'hFFFF_FFFF, 8'h93);
    do_load("R4", 1, 1'b1, 1'b0, 1'b0, 16'h0041, 32'h0000_0410, 32'hFFFF_FFFF, 8'h93);
  endtask

  task automatic t_mem_paths;  // R6 R7
    do_load("R6", 2, 1'b1, 1'b1, 1'b1, 16'h0010, 32'h00A0_0002, 32'h000F_FFFF, 8'h9B);
    do_load("R7", 3, 1'b1, 1'b0, 1'b0, 16'h0200, 32'h0000_2000, 32'h0000_FFFF, 8'h00);
  endtask

  task automatic t_sel_only;  // R9
    do_load("R9", 2, 1'b0, 1'b1, 1'b1, 16'h7777, 32'h00A0_0002, 32'h000F_FFFF, 8'h9B);
  endtask

  task automatic t_isolation;  // R11: segment 0 unchanged by the others
    do_load("R11", 0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 32'h000F_FFF0, 32'h0000_FFFF, 8'h00);
    do_load("R11", 1, 1'b0, 1'b1, 1'b1, 16'h0041, 32'h0000_0410, 32'hFFFF_FFFF, 8'h93);
  endtask

  initial begin
    t_reset();
    t_real_reg();
    t_big_limit();
    t_mem_paths();
    t_sel_only();
    t_isolation();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule